// File: doc/BRIEF.md
# Programmable Clock Divider Network

This block turns one master clock into the timing references used by a converter and a switched-capacitor supply, and it drives a shared clock pin in either direction. The master is either the on-chip oscillator, which also clocks the block's own logic, or an external clock arriving on the pin. A single source-select input picks the master and sets the pin direction at the same time. In internal mode the pin is an output whose frequency comes from its own divider. In external mode the pin is an input. Its rising edges are synchronised, divided by an input divider, and become the master ticks.

The converter and supply references leave the block as single-cycle clock enables (`adc_en`, `cp_en`) in the oscillator domain. Both are counted from the same master tick stream (`master_en`), so they stay in step. In internal mode the master ticks on every oscillator cycle, whatever the pin divider is set to. The pin output is a 50% duty level, and in the ÷1 setting it is the oscillator clock itself. Every divider holds a new ratio until its current period has finished, so no period is ever cut short.

There is no data stream here, so the block has no valid/ready handshake. All configuration inputs are plain static levels.

Top module: `clkdiv_net`

## Requirements
- R1: When `src_int` is 1, `pin_oe` is 1 and `master_en` is high on every cycle. When `src_int` is 0, `pin_oe` is 0. `pin_oe` follows `src_int` one cycle later.
- R2: `pin_sel` codes the pin output as 0 = off, 1 = ÷1 (oscillator passed through), 2 = ÷2, 3 = ÷4 of the oscillator. In external mode the pin divider is off.
- R3: In external mode, each rising edge of `pin_in` (after a two-flop synchroniser) is an input tick. `in_sel` codes 0 = off (no master ticks), 1 = ÷1, 2 = ÷2, 3 = ÷4 of those ticks, and the result drives `master_en`.
- R4: In internal mode the converter and supply dividers count every oscillator cycle, whatever the setting of `pin_sel`.
- R5: `cp_sel` codes 0..3 give one `cp_en` pulse per 32, 64, 128 and 256 master ticks.
- R6: `adc_sel` codes 0..3 give one `adc_en` pulse per 1, 2, 4 and 8 master ticks.
- R7: While reset is held, `pin_oe` is 1 and `pin_out` and `cp_en` are 0. After reset the pin divider starts in ÷2.
- R8: `adc_en` and `cp_en` are only ever high in a cycle in which `master_en` is high.
- R9: In the ÷2 and ÷4 settings, `pin_out` is high for exactly half of each period.
- R10: A divider that is set to off holds its output low.
- R11: A ratio change takes effect only after the divider's current period completes. A divider that is currently off takes a new setting at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock; clocks all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_int | input | 1 | 1 = internal master and pin output, 0 = external master and pin input |
| pin_sel | input | 2 | Pin output divider code |
| in_sel | input | 2 | External input divider code |
| adc_sel | input | 2 | Converter divider code |
| cp_sel | input | 2 | Supply divider code |
| pin_in | input | 1 | Clock pin input value |
| pin_out | output | 1 | Clock pin output value |
| pin_oe | output | 1 | Clock pin output enable |
| master_en | output | 1 | Master clock tick enable |
| adc_en | output | 1 | Converter clock enable |
| cp_en | output | 1 | Supply clock enable |

## Verification
On every cycle, assertions check the following. Each divider pulse coincides with an input tick. A divider changes ratio only at a period end or while it is off. An off divider stays silent. The pin direction follows the select bit. The converter and supply enables fall only on master ticks, and a synchronised pin edge lasts a single cycle. The actual frequencies, the duty of the pin output, the ÷1 pass-through, the independence of the internal dividers from the pin setting, and the exact length of the period that spans a ratio change can only be shown by the bench's scenarios. The bench shows them by counting pulses and toggles over fixed windows.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CNT_W = 8;   // wide enough for the largest ratio (256)
  localparam int EXP_W = 4;   // log2 ratio exponent width
  localparam int SEL_W = 2;

  typedef logic [EXP_W-1:0] exp_t;

  // pin / input divider codes
  localparam logic [SEL_W-1:0] SEL_OFF  = 2'd0;
  localparam int               CP_BASE  = 5;  // 2**5 = 32
endpackage

// File: rtl/clkdiv_edge_sync.sv
module clkdiv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

  // R3: a synchronised edge produces a single tick
  a_r3_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/clkdiv_pow2.sv
module clkdiv_pow2
  import clkdiv_pkg::*;
#(
  parameter int          CW      = CNT_W,
  parameter int          EW      = EXP_W,
  parameter logic        RST_OFF = 1'b0,
  parameter logic [EW-1:0] RST_EXP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          off_req,
  input  logic [EW-1:0] exp_req,
  output logic          pulse,
  output logic          level,
  output logic          unity
);
  logic [CW-1:0] cnt_q;
  logic          off_q;
  logic [EW-1:0] exp_q;
  logic [CW-1:0] mask;
  logic [CW-1:0] half;
  logic          term;

  assign mask  = ~({CW{1'b1}} << exp_q);
  assign half  = mask ^ (mask >> 1);
  assign term  = tick && !off_q && (cnt_q == mask);
  assign pulse = term;
  assign level = !off_q && ((cnt_q & half) != '0);
  assign unity = !off_q && (exp_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      off_q <= RST_OFF;
      exp_q <= RST_EXP;
    end else if (off_q) begin
      cnt_q <= '0;
      off_q <= off_req;
      exp_q <= exp_req;
    end else if (tick) begin
      if (cnt_q == mask) begin
        cnt_q <= '0;
        off_q <= off_req;
        exp_q <= exp_req;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R8: a divided pulse only falls on an input tick
  a_r8_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> tick);
  // R11: ratio changes only after a finished period or while off
  a_r11_change_at_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(exp_q) |-> ($past(term) || $past(off_q)));
  // R10: an off divider is silent and its count sits at zero
  a_r10_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && $past(off_q)) |-> (!pulse && !level && cnt_q == '0));
endmodule

// File: rtl/clkdiv_net.sv
module clkdiv_net
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_int,
  input  logic [1:0] pin_sel,
  input  logic [1:0] in_sel,
  input  logic [1:0] adc_sel,
  input  logic [1:0] cp_sel,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       master_en,
  output logic       adc_en,
  output logic       cp_en
);
  localparam exp_t PIN_RST_EXP = exp_t'(1);
  localparam exp_t CP_RST_EXP  = exp_t'(CP_BASE);

  logic src_q;
  logic ext_tick;
  logic in_pulse, in_level, in_unity;
  logic pin_level, pin_unity, pin_pulse;
  logic adc_level, adc_unity;
  logic cp_level, cp_unity;
  exp_t pin_exp, in_exp, adc_exp, cp_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b1;
    else        src_q <= src_int;
  end

  // off/÷1/÷2/÷4 codes map to exponent code-1
  assign pin_exp = exp_t'(pin_sel - 2'd1);
  assign in_exp  = exp_t'(in_sel - 2'd1);
  assign adc_exp = exp_t'(adc_sel);
  assign cp_exp  = exp_t'(cp_sel) + exp_t'(CP_BASE);

  clkdiv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .rise(ext_tick));

  clkdiv_pow2 #(.RST_OFF(1'b1), .RST_EXP('0)) u_in_div (
    .clk(clk), .rst_n(rst_n), .tick(ext_tick),
    .off_req(src_q || in_sel == SEL_OFF), .exp_req(in_exp),
    .pulse(in_pulse), .level(in_level), .unity(in_unity));

  clkdiv_pow2 #(.RST_OFF(1'b0), .RST_EXP(PIN_RST_EXP)) u_pin_div (
    .clk(clk), .rst_n(rst_n), .tick(1'b1),
    .off_req(!src_q || pin_sel == SEL_OFF), .exp_req(pin_exp),
    .pulse(pin_pulse), .level(pin_level), .unity(pin_unity));

  assign master_en = src_q | in_pulse;

  clkdiv_pow2 #(.RST_OFF(1'b0), .RST_EXP('0)) u_adc_div (
    .clk(clk), .rst_n(rst_n), .tick(master_en),
    .off_req(1'b0), .exp_req(adc_exp),
    .pulse(adc_en), .level(adc_level), .unity(adc_unity));

  clkdiv_pow2 #(.RST_OFF(1'b0), .RST_EXP(CP_RST_EXP)) u_cp_div (
    .clk(clk), .rst_n(rst_n), .tick(master_en),
    .off_req(1'b0), .exp_req(cp_exp),
    .pulse(cp_en), .level(cp_level), .unity(cp_unity));

  assign pin_oe  = src_q;
  assign pin_out = (pin_unity && rst_n) ? clk : pin_level;

  // R1: pin direction follows the select bit one cycle later
  a_r1_oe_tracks_select: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pin_oe == $past(src_int)));
  // R8: converter and supply enables only on master ticks
  a_r8_adc_on_master: assert property (@(posedge clk) disable iff (!rst_n)
    adc_en |-> master_en);
  a_r8_cp_on_master: assert property (@(posedge clk) disable iff (!rst_n)
    cp_en |-> master_en);
  // R2: the pin is never driven while it is an input and the divider settled off
  a_r2_pin_quiet_as_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_oe && $past(!pin_oe) && !pin_unity && !$past(pin_unity) && !pin_level) |-> !pin_out);
endmodule

// File: tb/clkdiv_net_tb.sv
`timescale 1ns/1ps
module clkdiv_net_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_int = 1'b1;
  logic [1:0] pin_sel = 2'd2, in_sel = 2'd0, adc_sel = 2'd0, cp_sel = 2'd0;
  logic pin_in = 1'b0;
  logic pin_out, pin_oe, master_en, adc_en, cp_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit ext_run = 0;

  always #2.5 clk = ~clk;

  clkdiv_net u_dut (
    .clk(clk), .rst_n(rst_n), .src_int(src_int), .pin_sel(pin_sel),
    .in_sel(in_sel), .adc_sel(adc_sel), .cp_sel(cp_sel), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .master_en(master_en),
    .adc_en(adc_en), .cp_en(cp_en));

  // external clock: period of 8 oscillator cycles
  initial begin
    forever begin
      @(negedge clk);
      if (ext_run) begin
        repeat (3) @(negedge clk);
        pin_in = ~pin_in;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // measure over 512 cycles: pin high samples, pin toggles, adc, cp, master
  task automatic measure(output int hi, output int tog, output int na,
                         output int nc, output int nm);
    logic prev;
    hi = 0; tog = 0; na = 0; nc = 0; nm = 0;
    step();
    prev = pin_out;
    for (int i = 0; i < 512; i++) begin
      step();
      if (pin_out) hi++;
      if (pin_out != prev) tog++;
      prev = pin_out;
      if (adc_en) na++;
      if (cp_en) nc++;
      if (master_en) nm++;
    end
  endtask

  // {pin_sel, adc_sel, cp_sel, exp_hi, exp_tog, exp_adc, exp_cp}
  typedef struct packed {
    logic [1:0] ps; logic [1:0] as; logic [1:0] cs;
    logic [9:0] hi; logic [9:0] tog; logic [9:0] na; logic [9:0] nc;
  } vec_t;
  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 2'd0, 2'd0, 10'd256, 10'd512, 10'd512, 10'd16},
    '{2'd3, 2'd1, 2'd1, 10'd256, 10'd256, 10'd256, 10'd8},
    '{2'd1, 2'd2, 2'd2, 10'd512, 10'd0,   10'd128, 10'd4},
    '{2'd0, 2'd3, 2'd3, 10'd0,   10'd0,   10'd64,  10'd2},
    '{2'd3, 2'd2, 2'd3, 10'd256, 10'd256, 10'd128, 10'd2}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, tog, na, nc, nm, n;
    // R7: reset state
    #12;
    check("R7 pin_oe in reset", int'(pin_oe), 1);
    check("R7 pin_out in reset", int'(pin_out), 0);
    check("R7 cp_en in reset", int'(cp_en), 0);
    @(negedge clk); rst_n = 1'b1;
    // R7/R9: default ÷2 straight after reset
    measure(hi, tog, na, nc, nm);
    check("R7 default pin ÷2 toggles", tog, 512);
    check("R9 default pin duty", hi, 256);

    // table of internal-mode settings: R2 R4 R5 R6 R9 R10 R1
    foreach (VECS[k]) begin
      pin_sel = VECS[k].ps; adc_sel = VECS[k].as; cp_sel = VECS[k].cs;
      repeat (600) step();
      measure(hi, tog, na, nc, nm);
      check("R2 R9 R10 pin high samples", hi, int'(VECS[k].hi));
      check("R2 pin toggles", tog, int'(VECS[k].tog));
      check("R6 R4 adc pulses", na, int'(VECS[k].na));
      check("R5 R4 cp pulses", nc, int'(VECS[k].nc));
      check("R1 master every cycle", nm, 512);
      check("R1 pin_oe internal", int'(pin_oe), 1);
    end

    // R2: ÷1 passes the oscillator: low during the low phase
    pin_sel = 2'd1; repeat (20) step();
    @(negedge clk); #1;
    check("R2 ÷1 low phase", int'(pin_out), 0);
    @(posedge clk); #1;
    check("R2 ÷1 high phase", int'(pin_out), 1);

    // R11: change cp from ÷256 to ÷32 mid period
    cp_sel = 2'd3; adc_sel = 2'd0; repeat (600) step();
    n = 0;
    while (!cp_en) step();
    step(); cp_sel = 2'd0; n = 1;
    while (!cp_en) begin step(); n++; end
    check("R11 old period completes", n, 256);
    n = 0;
    do begin step(); n++; end while (!cp_en);
    check("R11 new ratio applies", n, 32);

    // external mode: R3 R1 R2
    src_int = 1'b0; ext_run = 1; in_sel = 2'd1; adc_sel = 2'd0; cp_sel = 2'd0;
    repeat (3000) step();
    measure(hi, tog, na, nc, nm);
    check("R1 pin_oe external", int'(pin_oe), 0);
    check("R2 pin off as input", hi, 0);
    check("R3 ÷1 master ticks", nm, 64);
    check("R3 R6 adc ÷1 on ext", na, 64);
    in_sel = 2'd2; adc_sel = 2'd1; repeat (3000) step();
    measure(hi, tog, na, nc, nm);
    check("R3 ÷2 master ticks", nm, 32);
    check("R6 adc ÷2 on ext", na, 16);
    in_sel = 2'd3; adc_sel = 2'd0; repeat (3000) step();
    measure(hi, tog, na, nc, nm);
    check("R3 ÷4 master ticks", nm, 16);
    in_sel = 2'd0; repeat (3000) step();
    measure(hi, tog, na, nc, nm);
    check("R3 R10 input off no ticks", nm, 0);
    check("R10 adc silent when input off", na, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule